// File: doc/BRIEF.md
# UART Receiver with Error Flags

This block is the receive half of an asynchronous serial port. It watches a serial input line, using a 16x oversampling tick to find a start bit and then to sample each later bit at its centre. It assembles 8 data bits, least significant first, into a one-byte receive buffer. An optional parity bit follows the data, and then one or two stop bits. Each finished frame produces a one-cycle completion pulse. The block also updates a status byte that holds three sticky error flags: parity, framing and overrun.

A host reads the receive buffer and the status byte through two level outputs. Each has its own read strobe. A status read clears all three error flags. A data read marks the buffer as consumed. If a frame finishes while the buffer is still unread, the block raises the overrun flag, drops the new byte and keeps the old one. The receiver runs only while both the global enable and the receive enable are high. While either is low, the error flags are held at zero and the frame logic waits in idle.

Top module: `serial_rx_status`

## Requirements
- R1: After reset the status byte reads 0x00 and the buffer reads 0x00. The status byte carries the parity error at bit 2, the framing error at bit 1 and the overrun error at bit 0. Bits 7..3 always read zero.
- R2: A low level seen on a tick starts a start-bit check. The start bit is accepted only if the line is still low 8 ticks later. Otherwise the receiver returns to idle and no frame is produced.
- R3: Each bit lasts 16 ticks and is sampled at its centre. 8 data bits arrive LSB first. On the stop-bit sample the block pulses `rx_done_o` for exactly one cycle, and the buffer is loaded on the next clock edge. The buffer never changes at any other time.
- R4: `par_mode_i` selects the parity check: 00 = no parity bit and no check, 01 = the bit must be 0, 10 = odd parity over data plus bit, 11 = even parity over data plus bit. A mismatch sets status bit 2.
- R5: Only the first stop bit is checked. If it is low, status bit 1 is set. When `two_stop_i` is 1, the second stop bit is waited out but never checked.
- R6: If a frame completes while the buffer has not been read since the previous frame, status bit 0 is set, the new byte is discarded and the buffer keeps its old value. The flag stays set until it is cleared.
- R7: A pulse on `stat_rd_i` clears all three error flags.
- R8: While `uart_en_i` or `rx_en_i` is low, the error flags read zero and no frame is received.
- R9: When a frame completes in the same cycle as a status read, the flags that frame sets survive the read. When it completes in the same cycle as a data read, the buffer is loaded and stays marked unread, so the next frame overruns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uart_en_i | input | 1 | Global enable of the serial port |
| rx_en_i | input | 1 | Receive enable |
| rxd_i | input | 1 | Serial receive line, idle high |
| tick16_i | input | 1 | Oversampling strobe, 16 per bit time |
| par_mode_i | input | 2 | Parity mode: 00 none, 01 zero, 10 odd, 11 even |
| two_stop_i | input | 1 | 1 = two stop bits in the frame |
| data_rd_i | input | 1 | Host read strobe for the receive buffer |
| stat_rd_i | input | 1 | Host read strobe for the status byte |
| rx_data_o | output | DATA_BITS | Receive buffer |
| rx_stat_o | output | 8 | Status byte {00000, parity err, framing err, overrun} |
| rx_done_o | output | 1 | One-cycle pulse per completed frame |

## Verification
The bench sweeps data values under every parity mode and checks the buffer against the byte it sent and the status byte against a parity bit it computes itself. A receiver that inverted the odd/even sense, or checked parity in "none" mode, would flag clean frames. It sends frames whose second stop bit is low, which catches a design that checks both stop bits. It also sends back-to-back unread frames, which catches a design that overwrites the buffer on overrun. A short low glitch on the line must produce no frame; a receiver that skips the start-bit centre check would capture a bogus byte. Read strobes are placed exactly on the completion cycle, so a design that lets a clear win over a set would lose the new flags or the unread mark.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_PAR   = 3'd3,
        S_STOP  = 3'd4,
        S_STOP2 = 3'd5
    } rx_state_e;

    localparam int STAT_W = 8;

endpackage

// File: rtl/srx_parity.sv
module srx_parity
    import serial_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic [DATA_BITS-1:0] data_i,
    input  logic [1:0]           mode_i,
    input  logic                 par_bit_i,
    output logic                 par_err_o
);
    logic expect_bit;

    always_comb begin
        unique case (par_mode_e'(mode_i))
            PAR_ZERO: expect_bit = 1'b0;
            PAR_ODD:  expect_bit = ~(^data_i);
            PAR_EVEN: expect_bit = ^data_i;
            default:  expect_bit = par_bit_i;
        endcase
        par_err_o = (par_mode_e'(mode_i) != PAR_NONE) && (par_bit_i != expect_bit);
    end
endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import serial_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OSR       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_i,
    input  logic                 tick_i,
    input  logic                 rxd_i,
    input  logic                 par_on_i,
    input  logic                 two_stop_i,
    output logic                 frm_valid_o,
    output logic [DATA_BITS-1:0] frm_data_o,
    output logic                 frm_par_o,
    output logic                 frm_stop_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam int BIT_W = $clog2(DATA_BITS);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

    typedef struct packed {
        rx_state_e            st;
        logic [CNT_W-1:0]     cnt;
        logic [BIT_W-1:0]     nbit;
        logic [DATA_BITS-1:0] shf;
        logic                 par;
        logic                 stop;
        logic                 valid;
    } frm_t;

    frm_t frm_q, frm_d;

    always_comb begin
        frm_d       = frm_q;
        frm_d.valid = 1'b0;
        if (!run_i) begin
            frm_d.st  = S_IDLE;
            frm_d.cnt = '0;
        end else if (tick_i) begin
            unique case (frm_q.st)
                S_IDLE: begin
                    if (!rxd_i) begin
                        frm_d.st  = S_START;
                        frm_d.cnt = '0;
                    end
                end
                S_START: begin
                    if (frm_q.cnt == MID_CNT) begin
                        frm_d.cnt  = '0;
                        frm_d.nbit = '0;
                        frm_d.st   = rxd_i ? S_IDLE : S_DATA;
                    end else begin
                        frm_d.cnt = frm_q.cnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (frm_q.cnt == LAST_CNT) begin
                        frm_d.cnt = '0;
                        frm_d.shf = {rxd_i, frm_q.shf[DATA_BITS-1:1]};
                        if (frm_q.nbit == LAST_BIT) begin
                            frm_d.st = par_on_i ? S_PAR : S_STOP;
                        end else begin
                            frm_d.nbit = frm_q.nbit + 1'b1;
                        end
                    end else begin
                        frm_d.cnt = frm_q.cnt + 1'b1;
                    end
                end
                S_PAR: begin
                    if (frm_q.cnt == LAST_CNT) begin
                        frm_d.cnt = '0;
                        frm_d.par = rxd_i;
                        frm_d.st  = S_STOP;
                    end else begin
                        frm_d.cnt = frm_q.cnt + 1'b1;
                    end
                end
                S_STOP: begin
                    if (frm_q.cnt == LAST_CNT) begin
                        frm_d.cnt   = '0;
                        frm_d.stop  = rxd_i;
                        frm_d.valid = 1'b1;
                        frm_d.st    = two_stop_i ? S_STOP2 : S_IDLE;
                    end else begin
                        frm_d.cnt = frm_q.cnt + 1'b1;
                    end
                end
                S_STOP2: begin
                    if (frm_q.cnt == LAST_CNT) begin
                        frm_d.cnt = '0;
                        frm_d.st  = S_IDLE;
                    end else begin
                        frm_d.cnt = frm_q.cnt + 1'b1;
                    end
                end
                default: frm_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frm_q <= '0;
        else        frm_q <= frm_d;
    end

    assign frm_valid_o = frm_q.valid;
    assign frm_data_o  = frm_q.shf;
    assign frm_par_o   = frm_q.par;
    assign frm_stop_o  = frm_q.stop;
endmodule

// File: rtl/srx_holding.sv
module srx_holding #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_i,
    input  logic                 frm_valid_i,
    input  logic [DATA_BITS-1:0] frm_data_i,
    input  logic                 par_err_i,
    input  logic                 stop_i,
    input  logic                 data_rd_i,
    input  logic                 stat_rd_i,
    output logic [DATA_BITS-1:0] dat_o,
    output logic [2:0]           flags_o,
    output logic                 unread_o
);
    typedef struct packed {
        logic [DATA_BITS-1:0] dat;
        logic                 unread;
        logic                 pe;
        logic                 fe;
        logic                 ov;
    } hold_t;

    hold_t hold_q, hold_d;

    always_comb begin
        hold_d = hold_q;
        if (data_rd_i) hold_d.unread = 1'b0;
        if (stat_rd_i) begin
            hold_d.pe = 1'b0;
            hold_d.fe = 1'b0;
            hold_d.ov = 1'b0;
        end
        if (frm_valid_i) begin
            if (hold_q.unread) hold_d.ov  = 1'b1;
            else               hold_d.dat = frm_data_i;
            hold_d.unread = 1'b1;
            if (par_err_i) hold_d.pe = 1'b1;
            if (!stop_i)   hold_d.fe = 1'b1;
        end
        if (!run_i) begin
            hold_d.pe     = 1'b0;
            hold_d.fe     = 1'b0;
            hold_d.ov     = 1'b0;
            hold_d.unread = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign dat_o    = hold_q.dat;
    assign flags_o  = {hold_q.pe, hold_q.fe, hold_q.ov};
    assign unread_o = hold_q.unread;
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
    import serial_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OSR       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 uart_en_i,
    input  logic                 rx_en_i,
    input  logic                 rxd_i,
    input  logic                 tick16_i,
    input  logic [1:0]           par_mode_i,
    input  logic                 two_stop_i,
    input  logic                 data_rd_i,
    input  logic                 stat_rd_i,
    output logic [DATA_BITS-1:0] rx_data_o,
    output logic [STAT_W-1:0]    rx_stat_o,
    output logic                 rx_done_o
);
    logic                 run;
    logic                 frm_valid;
    logic [DATA_BITS-1:0] frm_data;
    logic                 frm_par;
    logic                 frm_stop;
    logic                 par_err;
    logic [2:0]           flags;
    logic                 buf_unread;

    assign run = uart_en_i & rx_en_i;

    srx_framer #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .tick_i      (tick16_i),
        .rxd_i       (rxd_i),
        .par_on_i    (par_mode_i != PAR_NONE),
        .two_stop_i  (two_stop_i),
        .frm_valid_o (frm_valid),
        .frm_data_o  (frm_data),
        .frm_par_o   (frm_par),
        .frm_stop_o  (frm_stop)
    );

    srx_parity #(.DATA_BITS(DATA_BITS)) u_parity (
        .data_i    (frm_data),
        .mode_i    (par_mode_i),
        .par_bit_i (frm_par),
        .par_err_o (par_err)
    );

    srx_holding #(.DATA_BITS(DATA_BITS)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .frm_valid_i (frm_valid),
        .frm_data_i  (frm_data),
        .par_err_i   (par_err),
        .stop_i      (frm_stop),
        .data_rd_i   (data_rd_i),
        .stat_rd_i   (stat_rd_i),
        .dat_o       (rx_data_o),
        .flags_o     (flags),
        .unread_o    (buf_unread)
    );

    assign rx_stat_o = {{(STAT_W-3){1'b0}}, flags};
    assign rx_done_o = frm_valid;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 uart_en_i,
    input logic                 rx_en_i,
    input logic                 stat_rd_i,
    input logic                 rx_done_o,
    input logic [DATA_BITS-1:0] rx_data_o,
    input logic [7:0]           rx_stat_o,
    input logic                 buf_unread
);
    // R3
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done_o |=> $stable(rx_data_o));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_o |=> !rx_done_o);

    // R6
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_o && buf_unread && uart_en_i && rx_en_i) |=> ($stable(rx_data_o) && rx_stat_o[0]));

    // R7
    stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !rx_done_o) |=> (rx_stat_o[2:0] == 3'b000));

    // R8
    dis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(uart_en_i && rx_en_i) |=> (rx_stat_o[2:0] == 3'b000));

    // R9
    unread_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_o && uart_en_i && rx_en_i) |=> buf_unread);
endmodule

bind serial_rx_status srx_checker #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .uart_en_i  (uart_en_i),
    .rx_en_i    (rx_en_i),
    .stat_rd_i  (stat_rd_i),
    .rx_done_o  (rx_done_o),
    .rx_data_o  (rx_data_o),
    .rx_stat_o  (rx_stat_o),
    .buf_unread (buf_unread)
);

// File: tb/serial_rx_status_tb.sv
module serial_rx_status_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uart_en = 1'b1;
    logic       rx_en = 1'b1;
    logic       rxd = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] pmode = 2'b00;
    logic       two_stop = 1'b0;
    logic       data_rd = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rx_data;
    logic [7:0] rx_stat;
    logic       rx_done;

    int errs = 0;
    int checks = 0;
    int done_cnt = 0;
    int done_base;
    bit finished = 1'b0;

    serial_rx_status u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .uart_en_i  (uart_en),
        .rx_en_i    (rx_en),
        .rxd_i      (rxd),
        .tick16_i   (tick),
        .par_mode_i (pmode),
        .two_stop_i (two_stop),
        .data_rd_i  (data_rd),
        .stat_rd_i  (stat_rd),
        .rx_data_o  (rx_data),
        .rx_stat_o  (rx_stat),
        .rx_done_o  (rx_done)
    );

    always #10 clk = ~clk;

    always @(negedge clk) tick <= ~tick;

    always @(posedge clk) if (rst_n && rx_done) done_cnt <= done_cnt + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic par_of(input logic [1:0] m, input logic [7:0] d);
        case (m)
            2'b01:   par_of = 1'b0;
            2'b10:   par_of = ~(^d);
            2'b11:   par_of = ^d;
            default: par_of = 1'b0;
        endcase
    endfunction

    task automatic bit_out(input logic b);
        rxd = b;
        repeat (32) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic pb, input logic s1, input logic s2);
        bit_out(1'b0);
        for (int i = 0; i < 8; i++) bit_out(d[i]);
        if (pmode != 2'b00) bit_out(pb);
        bit_out(s1);
        if (two_stop) bit_out(s2);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic rd_data();
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_stat();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_collide(input logic [7:0] d, input logic pb, input logic on_stat);
        fork
            send(d, pb, 1'b1, 1'b1);
            begin
                @(posedge rx_done);
                @(negedge clk);
                if (on_stat) stat_rd = 1'b1;
                else         data_rd = 1'b1;
                @(negedge clk);
                stat_rd = 1'b0;
                data_rd = 1'b0;
            end
        join
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset status", rx_stat, 8'h00);
        chk("R1 reset buffer", rx_data, 8'h00);
        chk("R1 reset done", rx_done, 1'b0);

        // R3 R4 sweep over parity modes and data values
        for (int m = 0; m < 4; m++) begin
            pmode = 2'(m);
            for (int v = 0; v < 256; v += 23) begin
                done_base = done_cnt;
                send(8'(v), par_of(pmode, 8'(v)), 1'b1, 1'b1);
                chk("R3 data LSB first", rx_data, 32'(v));
                chk("R4 good parity no flag", rx_stat, 8'h00);
                chk("R3 one done pulse", done_cnt - done_base, 1);
                rd_data();
                if (m != 0) begin
                    send(8'(v ^ 8'hFF), ~par_of(pmode, 8'(v ^ 8'hFF)), 1'b1, 1'b1);
                    chk("R4 bad parity flag bit2", rx_stat, 8'h04);
                    chk("R4 data kept on parity error", rx_data, 32'(v ^ 8'hFF));
                    rd_data();
                    rd_stat();
                    chk("R7 status read clears", rx_stat, 8'h00);
                end
            end
        end

        // R5 framing
        pmode = 2'b11;
        send(8'hA5, par_of(2'b11, 8'hA5), 1'b0, 1'b1);
        chk("R5 low stop sets bit1", rx_stat, 8'h02);
        rd_data();
        rd_stat();
        two_stop = 1'b1;
        send(8'h96, par_of(2'b11, 8'h96), 1'b1, 1'b0);
        chk("R5 second stop not checked", rx_stat, 8'h00);
        chk("R5 data with two stops", rx_data, 8'h96);
        rd_data();
        send(8'h69, par_of(2'b11, 8'h69), 1'b0, 1'b1);
        chk("R5 first of two stops checked", rx_stat, 8'h02);
        rd_data();
        rd_stat();
        two_stop = 1'b0;

        // R1 layout with two flags
        send(8'h0F, ~par_of(2'b11, 8'h0F), 1'b0, 1'b1);
        chk("R1 layout parity+framing", rx_stat, 8'h06);
        rd_data();
        rd_stat();

        // R6 overrun
        send(8'h5A, par_of(2'b11, 8'h5A), 1'b1, 1'b1);
        send(8'hC3, par_of(2'b11, 8'hC3), 1'b1, 1'b1);
        chk("R6 overrun keeps old byte", rx_data, 8'h5A);
        chk("R6 overrun flag bit0", rx_stat, 8'h01);
        rd_data();
        send(8'h3C, par_of(2'b11, 8'h3C), 1'b1, 1'b1);
        chk("R6 load after data read", rx_data, 8'h3C);
        chk("R6 overrun flag sticky", rx_stat, 8'h01);
        rd_stat();
        chk("R7 overrun cleared by read", rx_stat, 8'h00);
        rd_data();

        // R8 disable clears flags and blocks reception
        send(8'h11, par_of(2'b11, 8'h11), 1'b0, 1'b1);
        chk("R8 flag before disable", rx_stat, 8'h02);
        rd_data();
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 rx_en low clears flags", rx_stat, 8'h00);
        rx_en = 1'b1;
        uart_en = 1'b0;
        done_base = done_cnt;
        send(8'h77, par_of(2'b11, 8'h77), 1'b1, 1'b1);
        chk("R8 no frame while disabled", done_cnt - done_base, 0);
        chk("R8 buffer untouched while disabled", rx_data, 8'h11);
        uart_en = 1'b1;
        repeat (4) @(negedge clk);

        // R2 start glitch rejected
        done_base = done_cnt;
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (600) @(negedge clk);
        chk("R2 glitch gives no frame", done_cnt - done_base, 0);
        chk("R2 glitch buffer unchanged", rx_data, 8'h11);
        chk("R2 glitch no flags", rx_stat, 8'h00);

        // R9 collisions
        send_collide(8'h42, ~par_of(2'b11, 8'h42), 1'b1);
        chk("R9 parity flag survives same-cycle read", rx_stat, 8'h04);
        rd_data();
        rd_stat();
        send_collide(8'h81, par_of(2'b11, 8'h81), 1'b0);
        chk("R9 buffer loads on same-cycle read", rx_data, 8'h81);
        send(8'h18, par_of(2'b11, 8'h18), 1'b1, 1'b1);
        chk("R9 unread kept so next overruns", rx_stat, 8'h01);
        chk("R9 old byte kept", rx_data, 8'h81);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule